// File: doc/BRIEF.md
# Activity-Driven Pacing Interval Adjuster

This block keeps the interval, in milliseconds, that a pacing timer uses between two stimuli, and moves it with the wearer's level of physical activity. An activity classifier upstream delivers a 3-bit level on a sample strobe. When a sampled level differs from the level the block currently holds, the block stores it and picks a new target interval from a linear table. That table runs from the longest allowed interval at rest to the shortest allowed interval at full exertion, and medium activity lands on 750 ms.

The output interval never jumps to the target. On each update strobe it takes one bounded step toward the target. Shortening steps are sized from a reaction time and lengthening steps from a recovery time, with both times counted in update periods. The final step of a ramp is trimmed so that it lands exactly on the target. The interval therefore stays inside the band set by the upper and lower rate limits.

Top module: `activity_interval_adjuster`

## Requirements
- R1: After reset the interval output equals LRI_MS (longest interval), the target output equals LRI_MS and the held level is 0 (very low).
- R2: Level code 0 is very low, and codes 1 to 6 are low, medium-low, medium, medium-high, high and very high. Code 7 is treated as 6. The target for level L is LRI - floor((LRI-MID)*L/3) for L up to 3, and MID - floor((MID-URI)*(L-3)/3) above 3. MID is MID_MS when it lies in [URI_MS, LRI_MS] and (LRI_MS+URI_MS)/2 otherwise.
- R3: With level 3 (medium) held and enough update strobes, the interval settles at exactly 750 ms when defaults are used.
- R4: A sample strobe whose level equals the held level leaves the target unchanged. A differing level updates the target on the clock edge that samples it.
- R5: On an update strobe with interval above target, the interval drops by max(1, (LRI_MS-URI_MS)/REACT_UPD), or lands on the target if it is closer than that.
- R6: On an update strobe with interval below target, the interval rises by max(1, (LRI_MS-URI_MS)/RECOV_UPD), or lands on the target if it is closer than that.
- R7: Without an update strobe the interval does not change. An update strobe with interval equal to target also leaves it unchanged.
- R8: The interval and the target always stay within [URI_MS, LRI_MS].
- R9: A step never passes the target. A step taken on the same edge as a new sample uses the target held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Activity level valid strobe |
| act_level | input | 3 | Activity level code, 0 = very low to 6 = very high |
| step_stb | input | 1 | Update strobe, one ramp step per pulse |
| interval_ms | output | W | Current pacing interval in ms |
| target_ms | output | W | Interval currently being approached in ms |

## Verification
The bench uses the default parameters: a band from 500 to 1000 ms, a medium point of 750 ms, and reaction and recovery times of 20 and 40 update periods. These give a shortening step of 25 ms and a lengthening step of 12 ms. Neither step divides the gaps between most table entries, so trimmed final steps show up often in both directions. The 12 ms rise from 500 to 750 ends on a partial step. Random strobes and levels, including code 7, make sample and update strobes fall on the same edge. They also change the target in the middle of a ramp, in both directions.

// File: rtl/activity_interval_adjuster.sv
module activity_interval_adjuster #(
  parameter int W         = 12,
  parameter int LRI_MS    = 1000,
  parameter int URI_MS    = 500,
  parameter int MID_MS    = 750,
  parameter int REACT_UPD = 20,
  parameter int RECOV_UPD = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_stb,
  input  logic [2:0]   act_level,
  input  logic         step_stb,
  output logic [W-1:0] interval_ms,
  output logic [W-1:0] target_ms
);

  localparam int SPAN    = LRI_MS - URI_MS;
  localparam int MID     = (MID_MS >= URI_MS && MID_MS <= LRI_MS) ? MID_MS : (LRI_MS + URI_MS) / 2;
  localparam int DN_RAW  = SPAN / REACT_UPD;
  localparam int UP_RAW  = SPAN / RECOV_UPD;
  localparam int DN_STEP = (DN_RAW < 1) ? 1 : DN_RAW;
  localparam int UP_STEP = (UP_RAW < 1) ? 1 : UP_RAW;

  localparam logic [W-1:0] LRI_V = W'(LRI_MS);
  localparam logic [W-1:0] URI_V = W'(URI_MS);
  localparam logic [W-1:0] DN_V  = W'(DN_STEP);
  localparam logic [W-1:0] UP_V  = W'(UP_STEP);

  function automatic logic [W-1:0] level_target(input logic [2:0] lv);
    int l;
    int r;
    l = int'(lv);
    if (l <= 3) r = LRI_MS - ((LRI_MS - MID) * l) / 3;
    else        r = MID - ((MID - URI_MS) * (l - 3)) / 3;
    return W'(r);
  endfunction

  logic [2:0]   lvl_q;
  logic [2:0]   lvl_n;
  logic [W-1:0] tgt_q, int_q, int_d;
  logic [W-1:0] gap_dn, gap_up;
  logic         new_lvl;

  assign lvl_n   = (act_level == 3'd7) ? 3'd6 : act_level;
  assign new_lvl = sample_stb && (lvl_n != lvl_q);
  assign gap_dn  = int_q - tgt_q;
  assign gap_up  = tgt_q - int_q;

  always_comb begin
    int_d = int_q;
    if (step_stb) begin
      if (int_q > tgt_q)      int_d = (gap_dn > DN_V) ? int_q - DN_V : tgt_q;
      else if (int_q < tgt_q) int_d = (gap_up > UP_V) ? int_q + UP_V : tgt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 3'd0;
      tgt_q <= LRI_V;
      int_q <= LRI_V;
    end else begin
      int_q <= int_d;
      if (new_lvl) begin
        lvl_q <= lvl_n;
        tgt_q <= level_target(lvl_n);
      end
    end
  end

  assign interval_ms = int_q;
  assign target_ms   = tgt_q;

  p_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
    interval_ms >= URI_V && interval_ms <= LRI_V && target_ms >= URI_V && target_ms <= LRI_V);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_stb |=> $stable(interval_ms));

  p_same_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && lvl_n == lvl_q) |=> $stable(target_ms));

  p_shorten_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && interval_ms > target_ms) |=>
      (interval_ms < $past(interval_ms) && interval_ms >= $past(target_ms)
       && ($past(interval_ms) - interval_ms) <= DN_V));

  p_lengthen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && interval_ms < target_ms) |=>
      (interval_ms > $past(interval_ms) && interval_ms <= $past(target_ms)
       && (interval_ms - $past(interval_ms)) <= UP_V));

  p_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_ms == target_ms) |=> interval_ms == $past(interval_ms));

endmodule

// File: tb/activity_interval_adjuster_bench.sv
module activity_interval_adjuster_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sample_stb = 1'b0;
  logic [2:0]   act_level = 3'd0;
  logic         step_stb = 1'b0;
  logic [W-1:0] interval_ms, target_ms;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int m_lvl, m_tgt, m_int;

  always #4 clk = ~clk;

  activity_interval_adjuster u_activity_interval_adjuster (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .act_level(act_level),
    .step_stb(step_stb), .interval_ms(interval_ms), .target_ms(target_ms));

  function automatic int exp_target(input int lv);
    int l;
    l = (lv > 6) ? 6 : lv;
    if (l <= 3) return 1000 - (250 * l) / 3;
    return 750 - (250 * (l - 3)) / 3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit s, input int lv, input bit t);
    int ni;
    string tg;
    @(negedge clk);
    sample_stb = s;
    act_level  = 3'(lv);
    step_stb   = t;
    @(posedge clk);
    ni = m_int;
    tg = "R7";
    if (t && m_int > m_tgt) begin
      ni = (m_int - m_tgt > 25) ? m_int - 25 : m_tgt;
      tg = "R5";
    end else if (t && m_int < m_tgt) begin
      ni = (m_tgt - m_int > 12) ? m_int + 12 : m_tgt;
      tg = "R6";
    end
    m_int = ni;
    if (s && ((lv > 6) ? 6 : lv) != m_lvl) begin
      m_lvl = (lv > 6) ? 6 : lv;
      m_tgt = exp_target(m_lvl);
    end
    #1;
    check({tg, "/R9 interval"}, int'(interval_ms), m_int);
    check("R4 target", int'(target_ms), m_tgt);
    if (interval_ms < 500 || interval_ms > 1000) check("R8 band", int'(interval_ms), 750);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_lvl = 0; m_tgt = 1000; m_int = 1000;
    #1;
    check("R1 reset interval", int'(interval_ms), 1000);
    check("R1 reset target", int'(target_ms), 1000);

    cycle(1'b1, 0, 1'b1);
    check("R4 same level no change", int'(target_ms), 1000);

    for (int l = 1; l <= 7; l++) begin
      cycle(1'b1, l, 1'b0);
      check("R2 table", int'(target_ms), exp_target(l));
    end

    cycle(1'b1, 3, 1'b0);
    repeat (60) cycle(1'b0, 3, 1'b1);
    check("R3 medium settles", int'(interval_ms), 750);

    cycle(1'b1, 6, 1'b0);
    repeat (20) cycle(1'b0, 6, 1'b1);
    check("R8 floor reached", int'(interval_ms), 500);
    repeat (5) cycle(1'b0, 6, 1'b1);
    check("R7 settled hold", int'(interval_ms), 500);

    cycle(1'b1, 3, 1'b1);
    check("R9 old target used", int'(interval_ms), 500);
    repeat (21) cycle(1'b0, 3, 1'b1);
    check("R6 rise with trimmed last step", int'(interval_ms), 750);
    cycle(1'b0, 3, 1'b1);
    check("R9 no overshoot", int'(interval_ms), 750);

    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 8) == 0, int'($urandom % 8), ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule